// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel with Deferred Reload

This block drives one pulse-width-modulated output. Its frequency comes from a phase accumulator. Every clock the accumulator adds a programmable base-unit step, so the output repeats every 2^BU_W / step clocks. The top eight bits of the accumulator give the phase within the current period. The output is high while that phase is below 255 minus an 8-bit off-divisor. A divisor of zero therefore gives almost full duty, and 255 gives no high time at all.

Software controls the channel through a single 32-bit control word on a plain write/read port. Step and divisor writes land in a shadow copy. They reach the active copy only when software also sets the reload flag. The hardware then moves them at the next accumulator wrap, which is the start of a new output period, and clears the flag in the same cycle. Software polls the flag to learn when the new setting has taken hold.

When the channel is disabled there is no wrap, and a zero step never wraps either. In both cases a pending reload is applied on the very next clock, so polling software never waits forever.

Top module: `phase_pwm`

## Requirements
- R1: The control word reads back as follows: enable in bit 31, reload flag in bit 30, shadow step in bits [8 +: BU_W], shadow divisor in bits [7:0]. All other bits read as zero. A write updates these fields in the cycle after it is presented.
- R2: After reset the control word reads zero and `pwm_out` is low.
- R3: With an active step S that divides 2^BU_W, the output repeats every 2^BU_W/S clocks with exactly one rising edge per period, provided the duty is neither zero nor full.
- R4: Each period has exactly as many high clocks as there are values k in 0 .. P-1 for which (k*S) >> (BU_W-8) < 255 - D, where D is the active divisor and P is the period. A divisor of 255 keeps the output low.
- R5: A write with the reload flag at 0 changes only the shadow fields. The output keeps the old timing.
- R6: While the channel runs with a nonzero step, a reload waits for the accumulator wrap. At that wrap the flag clears and the new values take effect. The first clock of the new period is high unless the new divisor is 255.
- R7: While the reload flag is set, writes leave the step, the divisor and the flag untouched. Only the enable bit of such a write is accepted.
- R8: While enable is 0 the output is low and the accumulator is held at zero. A pending reload completes on the next clock.
- R9: An active step of zero freezes the accumulator and holds the output level. A reload requested in that state completes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Current control word |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions check the per-cycle rules on every clock:
- the output is low and the accumulator is zero while disabled;
- a pending reload clears one clock later when disabled or when the step is zero;
- the shadow fields are frozen while a reload is pending;
- the active copy stays still when no reload is pending;
- the accumulator holds on a zero step;
- a divisor of 255 keeps the output low.

Only the bench scenarios can show the properties that span many cycles. These are the count of high clocks and rising edges over whole periods for several step and divisor pairs, and the fact that a reload waits for the period boundary rather than acting at once. The same holds for the output edge that marks the new period and for the rejection of a write issued in mid-reload.

// File: rtl/pwm_pkg.sv
// Package: shared constants for the phase-accumulator PWM.
// Assumes a 32-bit control word with an 8-bit divisor in the low byte.
package pwm_pkg;
    localparam int CW_W     = 32;
    localparam int EN_BIT   = 31;
    localparam int RLD_BIT  = 30;
    localparam int STEP_LSB = 8;
    localparam int DIV_W    = 8;
    localparam int PH_W     = 8;
    localparam logic [DIV_W-1:0] DIV_FULL = 8'd255;

    // Phase limit below which the output is high
    function automatic logic [PH_W-1:0] high_limit(input logic [DIV_W-1:0] div);
        return DIV_FULL - div;
    endfunction
endpackage

// File: rtl/pwm_ctrl_reg.sv
// Module: control word, shadow copy, reload flag and active copy.
// Assumes BU_W is between 8 and 22 so that the step field fits below bit 30.
// While the reload flag is set, only the enable bit of a write is taken.
module pwm_ctrl_reg
    import pwm_pkg::*;
#(
    parameter int BU_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CW_W-1:0]  wdata,
    input  logic             wrap,
    output logic             en,
    output logic             rld,
    output logic             xfer,
    output logic [BU_W-1:0]  shd_step,
    output logic [DIV_W-1:0] shd_div,
    output logic [BU_W-1:0]  act_step,
    output logic [DIV_W-1:0] act_div,
    output logic [CW_W-1:0]  rdata
);
    localparam int FIELD_TOP = STEP_LSB + BU_W;

    // Reload fires at the wrap, or at once when no wrap can come
    always_comb begin
        xfer = rld && (!en || (act_step == '0) || wrap);
    end

    // Enable bit follows every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (wr) begin
            en <= wdata[EN_BIT];
        end
    end

    // Shadow fields and reload flag; frozen while a reload is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld      <= 1'b0;
            shd_step <= '0;
            shd_div  <= '0;
        end else if (rld) begin
            if (xfer) begin
                rld <= 1'b0;
            end
        end else if (wr) begin
            shd_step <= wdata[STEP_LSB +: BU_W];
            shd_div  <= wdata[DIV_W-1:0];
            rld      <= wdata[RLD_BIT];
        end
    end

    // Active copy loads from the shadow on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_step <= '0;
            act_div  <= '0;
        end else if (xfer) begin
            act_step <= shd_step;
            act_div  <= shd_div;
        end
    end

    // Read-back word assembly
    always_comb begin
        rdata = '0;
        rdata[EN_BIT] = en;
        rdata[RLD_BIT] = rld;
        rdata[STEP_LSB +: BU_W] = shd_step;
        rdata[DIV_W-1:0] = shd_div;
    end

    generate
        if (FIELD_TOP < RLD_BIT) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^wdata[RLD_BIT-1:FIELD_TOP];
        end
    endgenerate
endmodule

// File: rtl/pwm_phase_acc.sv
// Module: phase accumulator that adds the active step each clock.
// Assumes the accumulator is exactly as wide as the step; a carry marks a wrap.
// Held at zero while disabled, so no wrap is reported then.
module pwm_phase_acc #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] step,
    output logic [W-1:0] acc,
    output logic         wrap
);
    logic [W:0] sum;

    // Next phase with carry
    always_comb begin
        sum  = {1'b0, acc} + {1'b0, step};
        wrap = en && sum[W];
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum[W-1:0];
        end else begin
            acc <= '0;
        end
    end
endmodule

// File: rtl/pwm_duty_cmp.sv
// Module: compares the top phase byte with 255 minus the divisor.
// Assumes W >= 8. Output is registered and forced low when disabled.
module pwm_duty_cmp
    import pwm_pkg::*;
#(
    parameter int W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [W-1:0]     acc,
    input  logic [DIV_W-1:0] div,
    output logic             pwm
);
    logic [PH_W-1:0] phase;
    logic            hit;

    // Phase taken from the accumulator's top byte
    always_comb begin
        phase = acc[W-1 -: PH_W];
        hit   = phase < high_limit(div);
    end

    // Registered, enable-gated output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else begin
            pwm <= en && hit;
        end
    end

    generate
        if (W > PH_W) begin : g_low
            logic unused_low;
            assign unused_low = ^acc[W-PH_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/phase_pwm.sv
// Module: top of one PWM channel. Ties together the control register,
// the phase accumulator and the duty comparator.
// Assumes a single control word and no address decoding.
module phase_pwm
    import pwm_pkg::*;
#(
    parameter int BU_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [CW_W-1:0] cfg_wdata,
    output logic [CW_W-1:0] cfg_rdata,
    output logic            pwm_out
);
    logic             en;
    logic             rld;
    logic             xfer;
    logic             wrap;
    logic [BU_W-1:0]  shd_step;
    logic [DIV_W-1:0] shd_div;
    logic [BU_W-1:0]  act_step;
    logic [DIV_W-1:0] act_div;
    logic [BU_W-1:0]  acc;

    pwm_ctrl_reg #(.BU_W(BU_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .wrap     (wrap),
        .en       (en),
        .rld      (rld),
        .xfer     (xfer),
        .shd_step (shd_step),
        .shd_div  (shd_div),
        .act_step (act_step),
        .act_div  (act_div),
        .rdata    (cfg_rdata)
    );

    pwm_phase_acc #(.W(BU_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .step  (act_step),
        .acc   (acc),
        .wrap  (wrap)
    );

    pwm_duty_cmp #(.W(BU_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .acc   (acc),
        .div   (act_div),
        .pwm   (pwm_out)
    );

    logic unused_top;
    assign unused_top = ^{rld, xfer, shd_step, shd_div};
endmodule

// File: rtl/phase_pwm_chk.sv
// Module: assertion checker bound to phase_pwm.
// Watches the control word, the output and the active copy every clock.
module phase_pwm_chk #(
    parameter int BU_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [31:0]     rdata,
    input logic            pwm_out,
    input logic [BU_W-1:0] act_step,
    input logic [7:0]      act_div,
    input logic [BU_W-1:0] acc
);
    // R8: disabled forces the output low on the next clock
    p_low_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[31] |=> !pwm_out);

    // R8: accumulator held at zero while disabled
    p_acc_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[31] |=> (acc == '0));

    // R8: a pending reload clears after one clock while disabled
    p_rld_clear_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[30] && !rdata[31]) |=> !rdata[30]);

    // R9: a pending reload clears after one clock on a zero step
    p_rld_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[30] && act_step == '0) |=> !rdata[30]);

    // R9: a zero step freezes the accumulator
    p_acc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[31] && act_step == '0) |=> $stable(acc));

    // R7: shadow fields hold while a reload is pending
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[30] |=> $stable(rdata[29:0]));

    // R6: the active copy moves only through a reload
    p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[30] |=> ($stable(act_step) && $stable(act_div)));

    // R4: a divisor of 255 gives no high time
    p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div == 8'hFF) |=> !pwm_out);
endmodule

bind phase_pwm phase_pwm_chk #(.BU_W(BU_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdata    (cfg_rdata),
    .pwm_out  (pwm_out),
    .act_step (act_step),
    .act_div  (act_div),
    .acc      (acc)
);

// File: tb/phase_pwm_tb.sv
// Bench: scoreboard-based check of phase_pwm. The driver pushes expected
// period statistics into a queue; the monitor measures and compares them.
module phase_pwm_tb;
    localparam int BU_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    win;
        int    high;
        int    rises;
    } exp_t;

    exp_t exp_q[$];
    int   n_push = 0;
    int   n_done = 0;

    always #4 clk = ~clk;

    phase_pwm #(.BU_W(BU_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input bit rl, input int step, input int div);
        logic [31:0] w;
        w = '0;
        w[31] = en;
        w[30] = rl;
        w[8 +: BU_W] = step[BU_W-1:0];
        w[7:0] = div[7:0];
        return w;
    endfunction

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_rld_clear();
        for (int i = 0; i < 3000 && cfg_rdata[30]; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input bit en, input int step, input int div);
        wr(mk(en, 1'b1, step, div));
        wait_rld_clear();
        repeat (4) @(negedge clk);
    endtask

    // Driver side: expected statistics derived from the requirement formula
    task automatic expect_period(input string tag, input int step, input int div);
        exp_t e;
        int p;
        p = (1 << BU_W) / step;
        e.tag = tag;
        e.win = 2 * p;
        e.high = 0;
        for (int k = 0; k < p; k++) begin
            if (((k * step) >> (BU_W - 8)) < (255 - div)) e.high++;
        end
        e.rises = (e.high > 0 && e.high < p) ? 2 : 0;
        e.high = 2 * e.high;
        exp_q.push_back(e);
        n_push++;
        wait (n_done == n_push);
    endtask

    // Monitor: counts high clocks and rising edges over each window
    initial begin
        forever begin
            exp_t e;
            int hi;
            int rs;
            logic prev;
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            @(negedge clk);
            prev = pwm_out;
            hi = 0;
            rs = 0;
            for (int i = 0; i < e.win; i++) begin
                @(negedge clk);
                if (pwm_out) hi++;
                if (pwm_out && !prev) rs++;
                prev = pwm_out;
            end
            check({e.tag, " high clocks"}, hi, e.high);
            check({e.tag, " rising edges"}, rs, e.rises);
            n_done++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int hi;
        int cyc;
        logic v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 word", int'(cfg_rdata), 0);
        check("R2 output", int'(pwm_out), 0);

        // R1 readback and R8 reload while disabled
        wr(mk(1'b0, 1'b1, 16, 100));
        check("R1 word", int'(cfg_rdata), int'(mk(1'b0, 1'b1, 16, 100)));
        @(negedge clk);
        check("R8 reload cleared", int'(cfg_rdata[30]), 0);
        hi = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check("R8 low while off", hi, 0);

        // R4 and R3: run at several steps and divisors
        wr(mk(1'b1, 1'b0, 16, 100));
        repeat (4) @(negedge clk);
        expect_period("R4 s16 d100", 16, 100);
        set_cfg(1'b1, 16, 0);
        expect_period("R4 s16 d0", 16, 0);
        set_cfg(1'b1, 16, 255);
        expect_period("R4 s16 d255", 16, 255);
        set_cfg(1'b1, 4, 128);
        expect_period("R3 s4 d128", 4, 128);

        // R5: shadow write without reload keeps the old timing
        wr(mk(1'b1, 1'b0, 4, 10));
        check("R5 shadow readback", int'(cfg_rdata), int'(mk(1'b1, 1'b0, 4, 10)));
        expect_period("R5 unchanged", 4, 128);

        // R6 and R7: a reload waits for the wrap; a mid-reload write is ignored
        set_cfg(1'b1, 4, 200);
        @(negedge clk);
        while (!pwm_out) @(negedge clk);
        wr(mk(1'b1, 1'b1, 4, 50));
        repeat (10) @(negedge clk);
        wr(mk(1'b1, 1'b1, 16, 7));
        repeat (90) @(negedge clk);
        check("R6 reload still pending", int'(cfg_rdata[30]), 1);
        cyc = 0;
        while (cfg_rdata[30] && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        check("R6 last clock of old period", int'(pwm_out), 0);
        @(negedge clk);
        check("R6 new period starts high", int'(pwm_out), 1);
        check("R7 mid-reload write ignored", int'(cfg_rdata), int'(mk(1'b1, 1'b0, 4, 50)));
        repeat (4) @(negedge clk);
        expect_period("R7 s4 d50", 4, 50);

        // R7: enable still accepted while pending; R8 then clears it
        wr(mk(1'b1, 1'b1, 16, 20));
        wr(mk(1'b0, 1'b0, 4, 50));
        check("R7 enable taken", int'(cfg_rdata[31]), 0);
        @(negedge clk);
        check("R8 reload cleared after disable", int'(cfg_rdata[30]), 0);
        check("R8 output low", int'(pwm_out), 0);

        // R9: zero step freezes the output
        set_cfg(1'b1, 16, 60);
        set_cfg(1'b1, 0, 60);
        v = pwm_out;
        hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pwm_out != v) hi++;
        end
        check("R9 frozen output", hi, 0);
        wr(mk(1'b1, 1'b1, 16, 60));
        check("R9 reload pending", int'(cfg_rdata[30]), 1);
        @(negedge clk);
        check("R9 reload cleared", int'(cfg_rdata[30]), 0);
        repeat (4) @(negedge clk);
        expect_period("R9 resumed s16 d60", 16, 60);

        // R8: disable during a run
        wr(mk(1'b0, 1'b0, 16, 60));
        @(negedge clk);
        hi = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check("R8 low after disable", hi, 0);

        finish_run();
    end
endmodule